// File: doc/BRIEF.md
# Indirect Internal Register Access Bridge

A host with a 32-bit register port reaches a separate 16-bit internal register bus through this bridge. The host never drives the internal bus directly. It loads an address word and, for a write, a data word. It then writes an operation code to a command slot. The bridge runs exactly one transfer on the internal bus and holds the request until the responder acknowledges it. It then publishes a completion flag, a 2-bit response code and the 16-bit data in one result word, which the host polls.

To form the address word, the host shifts the byte address right by one and adds 0x30000. The internal bus sees only the low `ADDR_W` bits of that word, which is the 16-bit word address. A responder that never answers cannot hang the host. After `TIMEOUT_CYCLES` cycles the bridge completes the transfer on its own with response code 00. A polling host therefore always sees the ready flag well inside its 32-poll budget.

Host slots, selected by `host_sel`: 0 is the address word, 1 is the write data, 2 is the command (write-only, reads as 0) and 3 is the result word (read-only).

Top module: `top_reg_bridge`

## Requirements
- R1: After reset the result word reads 0x00000000 and `ib_req` is low.
- R2: Writing 1 to slot 2 while idle starts an internal write (`ib_wr`=1) that carries the write-data register on `ib_wdata`. Completion of the write sets ready and the status but leaves the data field unchanged.
- R3: Writing 1 or 2 to slot 2 while idle raises `ib_req` and clears the ready flag from the next cycle. Writing 2 starts an internal read (`ib_wr`=0). Ready stays clear until the transfer completes.
- R4: The result word has the ready flag in bit 18, the status in bits 17:16 and the data in bits 15:0. Bits 31:19 read as zero.
- R5: A transfer completes in the cycle `ib_ack` is sampled high. At that point ready becomes 1 and the status takes `ib_resp`, where 00 means no response, 01 OK, 10 request failed and 11 response error. A read also captures `ib_rdata` into the data field.
- R6: If `ib_ack` has not been sampled after `ib_req` has been high for `TIMEOUT_CYCLES` cycles, the bridge drops the request and completes with ready 1, status 00 and data 0xFFFF. An acknowledge in the last allowed cycle counts as a normal completion.
- R7: A command value other than 1 or 2 is ignored. No request is issued and the result word is unchanged.
- R8: A command written while a transfer is in progress is dropped. The address and operation of the running transfer stay stable until it ends.
- R9: The write-data slot keeps only the low 16 bits of the host word and reads back zero-extended.
- R10: The address slot reads back the full 32-bit word written. `ib_addr` carries its low `ADDR_W` bits, latched when the command starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the selected slot |
| host_sel | input | 2 | Slot select: 0 address, 1 write data, 2 command, 3 result |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read value of the selected slot (combinational) |
| ib_req | output | 1 | Internal request, held until acknowledge or timeout |
| ib_wr | output | 1 | Internal direction: 1 write, 0 read |
| ib_addr | output | ADDR_W | Internal 16-bit-word address |
| ib_wdata | output | 16 | Internal write data |
| ib_ack | input | 1 | Responder acknowledge |
| ib_resp | input | 2 | Responder response code |
| ib_rdata | input | 16 | Responder read data |

## Verification
The bench builds the bridge with `ADDR_W`=16 and `TIMEOUT_CYCLES`=8. The short timeout puts both edges of the time-out window within a few cycles: an acknowledge in the last allowed cycle, and a silent responder. The bench steps through the ready flag cycle by cycle at that boundary. The responder model's latency and response code can be changed between transfers. With that, all four status codes, a command dropped because a transfer is in progress, and invalid command values are each observed at the ports.

// File: rtl/top_reg_bridge.sv
module top_reg_bridge #(
  parameter int ADDR_W         = 16,
  parameter int TIMEOUT_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [1:0]        host_sel,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              ib_req,
  output logic              ib_wr,
  output logic [ADDR_W-1:0] ib_addr,
  output logic [15:0]       ib_wdata,
  input  logic              ib_ack,
  input  logic [1:0]        ib_resp,
  input  logic [15:0]       ib_rdata
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES) + 1;
  localparam logic [1:0] SEL_ADDR = 2'd0, SEL_WDAT = 2'd1, SEL_CMD = 2'd2, SEL_RES = 2'd3;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [31:0]       addr_q;
  logic [15:0]       wdat_q;
  logic              res_rdy_q;
  logic [1:0]        res_st_q;
  logic [15:0]       res_data_q;
  logic              busy_q;
  logic              op_wr_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [15:0]       op_wdata_q;
  logic [CNT_W-1:0]  cnt_q;

  wire cmd_hit  = host_wr && host_sel == SEL_CMD;
  wire cmd_wr   = cmd_hit && host_wdata == 32'd1;
  wire cmd_rd   = cmd_hit && host_wdata == 32'd2;
  wire start    = !busy_q && (cmd_wr || cmd_rd);
  wire done_ack = busy_q && ib_ack;
  wire expire   = busy_q && !ib_ack && cnt_q == CNT_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
    end else if (host_wr) begin
      if (host_sel == SEL_ADDR) addr_q <= host_wdata;
      if (host_sel == SEL_WDAT) wdat_q <= host_wdata[15:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      op_wr_q    <= 1'b0;
      op_addr_q  <= '0;
      op_wdata_q <= '0;
      cnt_q      <= '0;
    end else if (start) begin
      busy_q     <= 1'b1;
      op_wr_q    <= cmd_wr;
      op_addr_q  <= addr_q[ADDR_W-1:0];
      op_wdata_q <= wdat_q;
      cnt_q      <= '0;
    end else if (done_ack || expire) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_rdy_q  <= 1'b0;
      res_st_q   <= 2'b00;
      res_data_q <= '0;
    end else if (start) begin
      res_rdy_q <= 1'b0;
    end else if (done_ack) begin
      res_rdy_q <= 1'b1;
      res_st_q  <= ib_resp;
      if (!op_wr_q) res_data_q <= ib_rdata;
    end else if (expire) begin
      res_rdy_q  <= 1'b1;
      res_st_q   <= 2'b00;
      res_data_q <= 16'hFFFF;
    end
  end

  always_comb begin
    case (host_sel)
      SEL_ADDR: host_rdata = addr_q;
      SEL_WDAT: host_rdata = {16'h0, wdat_q};
      SEL_RES:  host_rdata = {13'h0, res_rdy_q, res_st_q, res_data_q};
      default:  host_rdata = '0;
    endcase
  end

  assign ib_req   = busy_q;
  assign ib_wr    = op_wr_q;
  assign ib_addr  = op_addr_q;
  assign ib_wdata = op_wdata_q;
endmodule

module top_reg_bridge_chk #(
  parameter int ADDR_W         = 16,
  parameter int TIMEOUT_CYCLES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic [1:0]        host_sel,
  input logic [31:0]       host_wdata,
  input logic              ib_req,
  input logic              ib_wr,
  input logic [ADDR_W-1:0] ib_addr,
  input logic              ib_ack,
  input logic [1:0]        ib_resp,
  input logic              res_rdy_q,
  input logic [1:0]        res_st_q
);
  int unsigned run_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run_cnt <= 0;
    else if (!ib_req) run_cnt <= 0;
    else run_cnt <= run_cnt + 1;

  wire valid_cmd = host_wr && host_sel == 2'd2 && (host_wdata == 32'd1 || host_wdata == 32'd2);

  p_ready_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ib_req && valid_cmd) |=> (ib_req && !res_rdy_q));

  p_done_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_req && ib_ack) |=> (!ib_req && res_rdy_q && res_st_q == $past(ib_resp)));

  p_req_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ib_req |-> run_cnt < TIMEOUT_CYCLES);

  p_no_spurious_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ib_req && !valid_cmd) |=> !ib_req);

  p_op_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_req && $past(ib_req)) |-> ($stable(ib_addr) && $stable(ib_wr)));
endmodule

bind top_reg_bridge top_reg_bridge_chk #(.ADDR_W(ADDR_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
  .ib_req(ib_req), .ib_wr(ib_wr), .ib_addr(ib_addr), .ib_ack(ib_ack), .ib_resp(ib_resp),
  .res_rdy_q(res_rdy_q), .res_st_q(res_st_q));

// File: tb/top_reg_bridge_tb.sv
`timescale 1ns/1ps
module top_reg_bridge_tb;
  localparam int AW = 16;
  localparam int TMO = 8;

  logic clk = 0, rst_n = 0;
  logic host_wr = 0;
  logic [1:0] host_sel = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic ib_req, ib_wr, ib_ack = 0;
  logic [AW-1:0] ib_addr;
  logic [15:0] ib_wdata, ib_rdata = 0;
  logic [1:0] ib_resp = 0;

  top_reg_bridge #(.ADDR_W(AW), .TIMEOUT_CYCLES(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .ib_req(ib_req), .ib_wr(ib_wr),
    .ib_addr(ib_addr), .ib_wdata(ib_wdata), .ib_ack(ib_ack), .ib_resp(ib_resp),
    .ib_rdata(ib_rdata));

  always #2 clk = ~clk;

  int nchecks = 0, nfail = 0;
  bit finished = 0;

  typedef struct {logic wr; logic [15:0] addr; logic [15:0] data;} exp_t;
  exp_t exp_q[$];

  int rsp_lat = 0, rsp_cnt = 0;
  logic [1:0] rsp_code = 2'b01;
  logic [15:0] rsp_data = 0;
  bit rsp_mute = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    ib_ack <= 1'b0;
    if (ib_req && !ib_ack && !rsp_mute) begin
      if (rsp_cnt == rsp_lat) begin
        ib_ack <= 1'b1; ib_resp <= rsp_code; ib_rdata <= rsp_data; rsp_cnt <= 0;
      end else rsp_cnt <= rsp_cnt + 1;
    end else rsp_cnt <= 0;
  end

  always @(negedge clk) begin
    if (rst_n && ib_req && ib_ack) begin
      if (exp_q.size() == 0) begin
        nchecks++; nfail++;
        $display("FAIL R8 unexpected transfer actual=%h expected=none", ib_addr);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R2 direction", {31'h0, ib_wr}, {31'h0, e.wr});
        chk("R10 address", {16'h0, ib_addr}, {16'h0, e.addr});
        if (e.wr) chk("R2 wdata", {16'h0, ib_wdata}, {16'h0, e.data});
      end
    end
  end

  task automatic host_write(logic [1:0] sel, logic [31:0] d);
    @(negedge clk); host_wr = 1; host_sel = sel; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic host_read(logic [1:0] sel, output logic [31:0] w);
    host_sel = sel; #1; w = host_rdata;
  endtask

  task automatic issue(bit wr, logic [15:0] addr, logic [15:0] data);
    exp_q.push_back('{wr, addr, data});
    host_write(2'd2, wr ? 32'd1 : 32'd2);
  endtask

  task automatic poll(output logic [31:0] w);
    host_sel = 2'd3;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); w = host_rdata;
      if (w[18]) return;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nchecks++; nfail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    host_read(2'd3, w); chk("R1 result", w, 32'h0);
    chk("R1 req", {31'h0, ib_req}, 32'h0);
    rst_n = 1;

    host_write(2'd1, 32'hABCD1234);
    host_read(2'd1, w); chk("R9 wdata low16", w, 32'h00001234);
    host_write(2'd0, (32'h1234 >> 1) + 32'h30000);
    host_read(2'd0, w); chk("R10 addr readback", w, 32'h0003091A);

    rsp_lat = 1; rsp_code = 2'b01;
    issue(1, 16'h091A, 16'h1234);
    poll(w); chk("R2 write done", w, 32'h00040000 | (32'h1 << 16));

    rsp_lat = 3; rsp_data = 16'hBEEF;
    issue(0, 16'h091A, 0);
    host_read(2'd3, w); chk("R3 ready cleared", {31'h0, w[18]}, 32'h0);
    poll(w); chk("R4 R5 read OK", w, 32'h0005BEEF);

    rsp_lat = 0; rsp_code = 2'b10; rsp_data = 16'h1111;
    issue(0, 16'h091A, 0);
    poll(w); chk("R5 failed", w, 32'h00061111);
    rsp_code = 2'b11; rsp_data = 16'h2121;
    issue(0, 16'h091A, 0);
    poll(w); chk("R5 resp error", w, 32'h00072121);
    rsp_code = 2'b00; rsp_data = 16'h3131;
    issue(0, 16'h091A, 0);
    poll(w); chk("R5 no response code", w, 32'h00043131);

    rsp_code = 2'b01; rsp_data = 16'h4444;
    issue(1, 16'h091A, 16'h1234);
    poll(w); chk("R2 data field kept", w, 32'h00053131);

    rsp_mute = 1;
    exp_q.delete();
    host_write(2'd2, 32'd2);
    host_sel = 2'd3;
    repeat (TMO - 1) @(negedge clk);
    chk("R6 not ready before window", {31'h0, host_rdata[18]}, 32'h0);
    @(negedge clk);
    chk("R6 timeout word", host_rdata, 32'h0004FFFF);
    chk("R6 req dropped", {31'h0, ib_req}, 32'h0);
    rsp_mute = 0;

    rsp_lat = TMO - 2; rsp_data = 16'h5555;
    issue(0, 16'h091A, 0);
    poll(w); chk("R6 last-cycle ack", w, 32'h00055555);

    host_write(2'd2, 32'd3);
    host_read(2'd3, w); chk("R7 code 3 ignored", w, 32'h00055555);
    chk("R7 no req", {31'h0, ib_req}, 32'h0);
    host_write(2'd2, 32'd0);
    host_read(2'd3, w); chk("R7 code 0 ignored", w, 32'h00055555);

    rsp_lat = 4; rsp_data = 16'h2222;
    host_write(2'd0, 32'h00030077);
    issue(0, 16'h0077, 0);
    host_write(2'd0, 32'h00030099);
    host_write(2'd2, 32'd1);
    poll(w); chk("R8 busy cmd dropped", w, 32'h00052222);
    repeat (12) @(negedge clk);
    chk("R8 no extra req", {31'h0, ib_req}, 32'h0);
    chk("R8 queue drained", exp_q.size(), 32'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule